// File: doc/BRIEF.md
# Loop Table Fetch Controller

This block sits between an instruction fetch unit and a program memory that costs a lot of power on every access. It watches the fetch stream and the branch outcomes that the core has already decoded. It spots small loops that the binary already contains: a loop shows up as a taken conditional branch whose target lies a short distance before the branch itself. Once it has seen such a loop, the block copies one full iteration into a local word buffer while that iteration is still being fetched from program memory. From the next iteration on, it supplies every instruction from the buffer and keeps the program memory enable low. Inside the loop, a local counter steps through the buffer entries, so no full-address lookup is made.

The instruction word is returned in the same cycle as its fetch, whichever source it comes from. The core therefore sees exactly the same timing with or without the block, and no opcodes or hints are added. The block stops serving a loop in two cases: when the closing branch falls through, or when any other control transfer is taken (a jump, call or interrupt).

A tuned mode lets an external profiling step install one chosen loop. The loop's bounds and instruction words are written through a configuration port and then locked. While the lock is set, the loop is served from its first iteration, it is never evicted, dynamic capture is disabled and further configuration writes are ignored. A hit counter records how many fetches the buffer served.

Top module: `lt_fetch_ctrl`

## Requirements
- R1: After reset the block is unlocked and idle, the hit counter reads 0, and program memory enable is low while no fetch is requested.
- R2: Fetches that do not belong to a captured loop go to program memory. This covers straight-line code, forward taken branches and backward branches that are not taken. For each such fetch, program memory enable is high in the fetch cycle and the instruction output equals the program memory data in that same cycle.
- R3: A loop is detected when a taken branch (branch valid and taken) at word address A has a target T with T < A and A − T ≤ DEPTH−1 (31 by default). The next iteration, from T to A, is still fetched from program memory and copied into the buffer. If that iteration ends with the same branch taken back to T, the block switches to serving from the buffer.
- R4: A taken backward branch whose distance A − T is DEPTH or more is ignored: all later iterations of that loop are fetched from program memory.
- R5: While serving, each fetch in the loop returns the word stored for that position, in the same cycle, with program memory enable low.
- R6: When the closing branch is not taken, its own fetch is still served from the buffer. The next fetch goes to program memory.
- R7: A taken other-transfer (jump, call or interrupt) during capture or serving cancels the loop. The fetch after it goes to program memory, and the loop must be detected again from scratch.
- R8: After a bounds write (start, end with end − start ≤ DEPTH−1), word writes (buffer index i holds the word for address start+i) and a lock pulse, a fetch at the start address is served from the buffer from the very first iteration. Serving continues for as long as the closing branch at the end address is taken.
- R9: While locked, no other loop is captured, and further bound writes, word writes and lock pulses have no effect on the installed loop.
- R10: The hit counter increments by exactly one for every fetch served from the buffer, and holds otherwise.
- R11: A cycle with no fetch request leaves the loop state unchanged and keeps program memory enable low, even in the middle of a served loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A fetch is requested this cycle |
| fetchAddr | input | AW | Word address of the fetch |
| brValid | input | 1 | The fetched word is a conditional branch whose outcome is known |
| brTaken | input | 1 | That branch is taken |
| brTarget | input | AW | Word address the branch jumps to |
| othXfer | input | 1 | Another control transfer (jump, call, interrupt) is taken at this fetch |
| pmemRdata | input | DW | Program memory read data, valid in the cycle pmemEn is high |
| pmemEn | output | 1 | Program memory access enable |
| instr | output | DW | Instruction word returned to the core |
| cfgBoundsWe | input | 1 | Write tuned loop bounds |
| cfgStart | input | AW | Tuned loop start word address |
| cfgEnd | input | AW | Tuned loop end word address (closing branch) |
| cfgWordWe | input | 1 | Write one tuned buffer word |
| cfgIdx | input | $clog2(DEPTH) | Buffer index of the word written |
| cfgWord | input | DW | Word written to the buffer |
| cfgLock | input | 1 | Pulse that locks the tuned loop until reset |
| hitCount | output | HIT_W | Number of fetches served from the buffer |

## Verification
The instruction word and the program memory enable belong to the fetch cycle itself. The bench therefore samples them at the falling edge of that cycle, against an expectation pushed when the fetch was driven. A mode change caused by a fetch (capture, serve, exit, cancel) first shows up at the next fetch, so the expectation for each iteration is given per iteration. The hit counter is one cycle behind: it is read at the falling edge after an idle cycle and compared with the count of served fetches that the bench predicts. While the program memory enable is low, the bench's memory model returns a poison word, so a word that comes from the wrong source or sits in the wrong buffer entry shows up as a wrong instruction.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_ACTIVE = 2'd2
  } ltState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic serve;    // this fetch is answered by the buffer
    logic capture;  // latch loop bounds from the detected branch
    logic fillWr;   // copy program memory data into the buffer
    logic cfgOpen;  // configuration writes accepted
  } ltStrobe_t;

endpackage

// File: rtl/lt_ctrl.sv
module lt_ctrl
  import lt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchValid,
  input  logic [AW-1:0] fetchAddr,
  input  logic          brValid,
  input  logic          brTaken,
  input  logic [AW-1:0] brTarget,
  input  logic          othXfer,
  input  logic          cfgLock,
  input  logic [AW-1:0] loopStart,
  input  logic [IW-1:0] loopLen,
  output ltStrobe_t     stb,
  output logic [IW-1:0] bufIdx,
  output ltState_e      state,
  output logic          locked
);

  localparam logic [AW-1:0] MaxDist = AW'(DEPTH - 1);

  ltState_e      stateN;
  logic [IW-1:0] cnt, cntN;
  logic          lockedN;

  logic [AW-1:0] backDist;
  logic          shortBack, trigger, tunedEntry, inLoop;
  logic [IW-1:0] curIdx;
  logic          atEnd, closeBack, fillSeqOk, fillEnd;

  assign backDist   = fetchAddr - brTarget;
  assign shortBack  = brValid && brTaken && (brTarget < fetchAddr) && (backDist <= MaxDist);
  assign trigger    = (state == ST_IDLE) && !locked && fetchValid && shortBack && !othXfer;
  assign tunedEntry = (state == ST_IDLE) && locked && fetchValid && (fetchAddr == loopStart);
  assign inLoop     = (state == ST_ACTIVE) || tunedEntry;
  assign curIdx     = (state == ST_ACTIVE) ? cnt : '0;
  assign atEnd      = (curIdx == loopLen);
  assign closeBack  = brValid && brTaken && (brTarget == loopStart);
  assign fillSeqOk  = (fetchAddr == loopStart + AW'(cnt));
  assign fillEnd    = (cnt == loopLen);

  always_comb begin
    stb.serve   = inLoop && fetchValid;
    stb.capture = trigger;
    stb.fillWr  = (state == ST_FILL) && fetchValid && fillSeqOk;
    stb.cfgOpen = !locked;
    bufIdx      = (state == ST_FILL) ? cnt : curIdx;
  end

  always_comb begin
    stateN  = state;
    cntN    = cnt;
    lockedN = locked;
    if (cfgLock && !locked) begin
      lockedN = 1'b1;
      stateN  = ST_IDLE;
      cntN    = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trigger) begin
            stateN = ST_FILL;
            cntN   = '0;
          end else if (tunedEntry) begin
            if (othXfer)                       stateN = ST_IDLE;
            else if (atEnd)                    stateN = closeBack ? ST_ACTIVE : ST_IDLE;
            else if (brValid && brTaken)       stateN = ST_IDLE;
            else begin
              stateN = ST_ACTIVE;
              cntN   = curIdx + 1'b1;
            end
            if (atEnd) cntN = '0;
          end
        end
        ST_FILL: begin
          if (fetchValid) begin
            if (!fillSeqOk || othXfer)         stateN = ST_IDLE;
            else if (fillEnd)                  stateN = closeBack ? ST_ACTIVE : ST_IDLE;
            else if (brValid && brTaken)       stateN = ST_IDLE;
            else                               cntN   = cnt + 1'b1;
            if (fillEnd) cntN = '0;
          end
        end
        ST_ACTIVE: begin
          if (fetchValid) begin
            if (othXfer)                       stateN = ST_IDLE;
            else if (atEnd)                    stateN = closeBack ? ST_ACTIVE : ST_IDLE;
            else if (brValid && brTaken)       stateN = ST_IDLE;
            else                               cntN   = cnt + 1'b1;
            if (atEnd) cntN = '0;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      state  <= stateN;
      cnt    <= cntN;
      locked <= lockedN;
    end
  end

endmodule

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int HIT_W = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ltStrobe_t        stb,
  input  logic [IW-1:0]    bufIdx,
  input  logic [AW-1:0]    fetchAddr,
  input  logic [AW-1:0]    brTarget,
  input  logic [DW-1:0]    pmemRdata,
  input  logic             cfgBoundsWe,
  input  logic [AW-1:0]    cfgStart,
  input  logic [AW-1:0]    cfgEnd,
  input  logic             cfgWordWe,
  input  logic [IW-1:0]    cfgIdx,
  input  logic [DW-1:0]    cfgWord,
  output logic [AW-1:0]    loopStart,
  output logic [IW-1:0]    loopLen,
  output logic [DW-1:0]    instr,
  output logic [HIT_W-1:0] hitCount
);

  logic [DW-1:0] loopBuf [DEPTH];
  logic [AW-1:0] capSpan, cfgSpan;

  assign capSpan = fetchAddr - brTarget;
  assign cfgSpan = cfgEnd - cfgStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopStart <= '0;
      loopLen   <= '0;
    end else if (stb.capture) begin
      loopStart <= brTarget;
      loopLen   <= capSpan[IW-1:0];
    end else if (stb.cfgOpen && cfgBoundsWe) begin
      loopStart <= cfgStart;
      loopLen   <= cfgSpan[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillWr)                     loopBuf[bufIdx] <= pmemRdata;
    else if (stb.cfgOpen && cfgWordWe)  loopBuf[cfgIdx] <= cfgWord;
  end

  assign instr = stb.serve ? loopBuf[bufIdx] : pmemRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hitCount <= '0;
    else if (stb.serve) hitCount <= hitCount + 1'b1;
  end

endmodule

// File: rtl/lt_fetch_ctrl.sv
module lt_fetch_ctrl
  import lt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int HIT_W = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [AW-1:0]    fetchAddr,
  input  logic             brValid,
  input  logic             brTaken,
  input  logic [AW-1:0]    brTarget,
  input  logic             othXfer,
  input  logic [DW-1:0]    pmemRdata,
  output logic             pmemEn,
  output logic [DW-1:0]    instr,
  input  logic             cfgBoundsWe,
  input  logic [AW-1:0]    cfgStart,
  input  logic [AW-1:0]    cfgEnd,
  input  logic             cfgWordWe,
  input  logic [IW-1:0]    cfgIdx,
  input  logic [DW-1:0]    cfgWord,
  input  logic             cfgLock,
  output logic [HIT_W-1:0] hitCount
);

  ltStrobe_t     stb;
  logic [IW-1:0] bufIdx;
  logic [AW-1:0] loopStart;
  logic [IW-1:0] loopLen;
  ltState_e      curState;
  logic          lockedQ;

  lt_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .brValid(brValid), .brTaken(brTaken), .brTarget(brTarget),
    .othXfer(othXfer), .cfgLock(cfgLock),
    .loopStart(loopStart), .loopLen(loopLen),
    .stb(stb), .bufIdx(bufIdx), .state(curState), .locked(lockedQ)
  );

  lt_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .HIT_W(HIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bufIdx(bufIdx),
    .fetchAddr(fetchAddr), .brTarget(brTarget), .pmemRdata(pmemRdata),
    .cfgBoundsWe(cfgBoundsWe), .cfgStart(cfgStart), .cfgEnd(cfgEnd),
    .cfgWordWe(cfgWordWe), .cfgIdx(cfgIdx), .cfgWord(cfgWord),
    .loopStart(loopStart), .loopLen(loopLen),
    .instr(instr), .hitCount(hitCount)
  );

  assign pmemEn = fetchValid && !stb.serve;

endmodule

// File: rtl/lt_fetch_ctrl_chk.sv
module lt_fetch_ctrl_chk
  import lt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 32,
  parameter int HIT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic [AW-1:0]    fetchAddr,
  input logic             brValid,
  input logic             brTaken,
  input logic [AW-1:0]    brTarget,
  input logic             othXfer,
  input logic             cfgLock,
  input logic             pmemEn,
  input logic [HIT_W-1:0] hitCount,
  input ltState_e         curState,
  input logic             lockedQ
);

  localparam logic [AW-1:0] Reach = AW'(DEPTH);

  AST_FILL_USES_PMEM: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_FILL && fetchValid) |-> pmemEn);  // R3

  AST_LONG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && !lockedQ && fetchValid && brValid && brTaken &&
     brTarget < fetchAddr && (fetchAddr - brTarget) >= Reach) |=> curState == ST_IDLE);  // R4

  AST_ACTIVE_NO_PMEM: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ACTIVE) |-> !pmemEn);  // R5

  AST_CANCEL_ON_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_IDLE && fetchValid && othXfer) |=> curState == ST_IDLE);  // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> lockedQ);  // R9

  AST_NO_FILL_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |-> curState != ST_FILL);  // R9

  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !pmemEn) |=> hitCount == $past(hitCount) + 1'b1);  // R10

  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchValid && !pmemEn) |=> $stable(hitCount));  // R10

  AST_BUBBLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && !cfgLock) |=> $stable(curState));  // R11

endmodule

bind lt_fetch_ctrl lt_fetch_ctrl_chk #(.AW(AW), .DEPTH(DEPTH), .HIT_W(HIT_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
  .brValid(brValid), .brTaken(brTaken), .brTarget(brTarget), .othXfer(othXfer),
  .cfgLock(cfgLock), .pmemEn(pmemEn), .hitCount(hitCount),
  .curState(curState), .lockedQ(lockedQ)
);

// File: tb/lt_fetch_ctrl_tb.sv
module lt_fetch_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 32;
  localparam int HIT_W = 16;
  localparam int IW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0, brValid = 1'b0, brTaken = 1'b0, othXfer = 1'b0;
  logic [AW-1:0] fetchAddr = '0, brTarget = '0;
  logic [DW-1:0] pmemRdata;
  logic pmemEn;
  logic [DW-1:0] instr;
  logic cfgBoundsWe = 1'b0, cfgWordWe = 1'b0, cfgLock = 1'b0;
  logic [AW-1:0] cfgStart = '0, cfgEnd = '0;
  logic [IW-1:0] cfgIdx = '0;
  logic [DW-1:0] cfgWord = '0;
  logic [HIT_W-1:0] hitCount;

  int total = 0, bad = 0, expHits = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [DW-1:0] word;
    logic          pen;
    string         tag;
  } expItem_t;
  expItem_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return {16'h5A3C ^ {a[7:0], a[15:8]}, a};
  endfunction

  // program memory model: poison while not enabled
  assign pmemRdata = pmemEn ? memWord(fetchAddr) : 32'hDEAD_BEEF;

  lt_fetch_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .HIT_W(HIT_W)) u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .brValid(brValid), .brTaken(brTaken), .brTarget(brTarget), .othXfer(othXfer),
    .pmemRdata(pmemRdata), .pmemEn(pmemEn), .instr(instr),
    .cfgBoundsWe(cfgBoundsWe), .cfgStart(cfgStart), .cfgEnd(cfgEnd),
    .cfgWordWe(cfgWordWe), .cfgIdx(cfgIdx), .cfgWord(cfgWord),
    .cfgLock(cfgLock), .hitCount(hitCount)
  );

  task automatic clearIns();
    fetchValid = 0; brValid = 0; brTaken = 0; othXfer = 0;
    cfgBoundsWe = 0; cfgWordWe = 0; cfgLock = 0;
  endtask

  // driver: one fetch per cycle, expectation pushed to the scoreboard
  task automatic fetch(input logic [AW-1:0] a, input logic bv, input logic bt,
                       input logic [AW-1:0] tgt, input logic ox,
                       input logic serve, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    clearIns();
    fetchValid = 1; fetchAddr = a; brValid = bv; brTaken = bt;
    brTarget = tgt; othXfer = ox;
    it.word = memWord(a); it.pen = !serve; it.tag = tag;
    sb.push_back(it);
    if (serve) expHits++;
  endtask

  task automatic iter(input logic [AW-1:0] s, input int len, input logic closeTaken,
                      input logic serve, input string tag);
    for (int i = 0; i <= len; i++)
      fetch(s + AW'(i), i == len, (i == len) && closeTaken, s, 1'b0, serve, tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bubble(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; clearIns();
      @(negedge clk);
      check(pmemEn == 1'b0, tag, pmemEn, 0);
    end
  endtask

  task automatic checkHits(input string tag);
    @(posedge clk); #1; clearIns();
    @(negedge clk);
    check(hitCount == HIT_W'(expHits), tag, hitCount, expHits);
  endtask

  task automatic cfgCycle(input logic bw, input logic [AW-1:0] s, input logic [AW-1:0] e,
                          input logic ww, input logic [IW-1:0] ix, input logic [DW-1:0] w,
                          input logic lk);
    @(posedge clk); #1; clearIns();
    cfgBoundsWe = bw; cfgStart = s; cfgEnd = e;
    cfgWordWe = ww; cfgIdx = ix; cfgWord = w; cfgLock = lk;
  endtask

  // monitor: pops one expectation per requested fetch
  always @(negedge clk) begin
    if (rstN && fetchValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "scoreboard-empty", 0, 1);
      end else begin
        expItem_t it;
        it = sb.pop_front();
        check(instr == it.word, it.tag, instr, it.word);
        check(pmemEn == it.pen, it.tag, pmemEn, it.pen);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clearIns();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(pmemEn == 1'b0, "R1", pmemEn, 0);
    check(hitCount == '0, "R1", hitCount, 0);

    // R2: straight line, forward taken branch, not-taken backward branch
    fetch(16'd10, 0, 0, 0, 0, 0, "R2");
    fetch(16'd11, 0, 0, 0, 0, 0, "R2");
    fetch(16'd12, 1, 1, 16'd30, 0, 0, "R2");
    fetch(16'd30, 1, 0, 16'd28, 0, 0, "R2");
    fetch(16'd31, 0, 0, 0, 0, 0, "R2");

    // R3/R5/R6/R11: loop 100..103
    iter(16'd100, 3, 1, 0, "R3");   // detection iteration
    iter(16'd100, 3, 1, 0, "R3");   // capture iteration
    iter(16'd100, 3, 1, 1, "R5");
    bubble(2, "R11");
    iter(16'd100, 3, 1, 1, "R11");
    iter(16'd100, 3, 0, 1, "R6");   // exit iteration, closing fetch still served
    fetch(16'd104, 0, 0, 0, 0, 0, "R6");
    checkHits("R10");

    // R3 boundary: distance DEPTH-1 is captured
    iter(16'd400, 31, 1, 0, "R3");
    iter(16'd400, 31, 1, 0, "R3");
    iter(16'd400, 31, 1, 1, "R3");
    iter(16'd400, 31, 0, 1, "R6");
    fetch(16'd432, 0, 0, 0, 0, 0, "R6");

    // R4: distance DEPTH is ignored
    iter(16'd500, 32, 1, 0, "R4");
    iter(16'd500, 32, 1, 0, "R4");
    iter(16'd500, 32, 1, 0, "R4");
    iter(16'd500, 32, 0, 0, "R4");

    // R7: cancel while serving
    iter(16'd600, 2, 1, 0, "R7");
    iter(16'd600, 2, 1, 0, "R7");
    iter(16'd600, 2, 1, 1, "R7");
    fetch(16'd600, 0, 0, 0, 1, 1, "R7");
    fetch(16'd700, 0, 0, 0, 0, 0, "R7");
    fetch(16'd701, 0, 0, 0, 0, 0, "R7");

    // R7: cancel while capturing, then detect again
    iter(16'd800, 2, 1, 0, "R7");
    fetch(16'd800, 0, 0, 0, 1, 0, "R7");
    fetch(16'd900, 0, 0, 0, 0, 0, "R7");
    iter(16'd800, 2, 1, 0, "R7");
    iter(16'd800, 2, 1, 0, "R7");
    iter(16'd800, 2, 0, 1, "R7");
    checkHits("R10");

    // R8: tuned loop 1000..1005
    cfgCycle(1, 16'd1000, 16'd1005, 0, '0, '0, 0);
    for (int i = 0; i < 6; i++)
      cfgCycle(0, '0, '0, 1, IW'(i), memWord(16'd1000 + AW'(i)), 0);
    cfgCycle(0, '0, '0, 0, '0, '0, 1);
    iter(16'd1000, 5, 1, 1, "R8");
    iter(16'd1000, 5, 1, 1, "R8");
    iter(16'd1000, 5, 0, 1, "R8");
    fetch(16'd1006, 0, 0, 0, 0, 0, "R8");

    // R9: dynamic capture disabled while locked
    iter(16'd1100, 2, 1, 0, "R9");
    iter(16'd1100, 2, 1, 0, "R9");
    iter(16'd1100, 2, 1, 0, "R9");
    iter(16'd1100, 2, 0, 0, "R9");
    // R9: configuration writes ignored while locked
    cfgCycle(1, 16'd1100, 16'd1102, 0, '0, '0, 0);
    cfgCycle(0, '0, '0, 1, '0, 32'h0BAD_0BAD, 0);
    cfgCycle(0, '0, '0, 0, '0, '0, 1);
    fetch(16'd1100, 0, 0, 0, 0, 0, "R9");
    iter(16'd1000, 5, 1, 1, "R9");
    iter(16'd1000, 5, 0, 1, "R9");
    checkHits("R10");

    bubble(2, "R11");
    check(sb.size() == 0, "scoreboard-drain", sb.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule